// File: doc/BRIEF.md
# Two-Phase Instruction Register with Opcode Hold

This block captures an instruction from an 8-bit bus in two parts. Each load strobe switches where the next byte goes. The first load after reset or step zero goes to a 4-bit opcode register. The second load goes to an 8-bit operand register.

When the operand load that ends a fetch is accepted, a hold latch sets and the opcode is shown as valid. From then on, every load strobe writes only the operand register. This lets microcode run the fetch micro-steps again inside an instruction to pull in extra operand bytes while the decoded opcode stays as it is.

An active-low step-zero input points the next load back at the opcode register. A synchronous latch-clear input drops the hold latch and also resets the switching. An asynchronous active-low reset clears everything.

Top module: `split_ir`

## Requirements
- R1: While reset is asserted, and right after it, opcode reads 0, operand reads 0x00 and op_valid is 0. Asserting rst_n low clears all of these at once, without waiting for a clock edge.
- R2: The first accepted load after reset, step zero or latch clear stores bus bits [7:4] as the opcode. The next accepted load stores the full bus byte as the operand, which appears after that rising edge.
- R3: op_valid rises on the rising edge that accepts the operand load ending a fetch. While op_valid is 0, the opcode output reads 0.
- R4: While op_valid is 1, every accepted load writes only the operand, and the opcode output does not change.
- R5: A cycle with step0_n low points the next load at the opcode register. A load strobe in that same cycle is ignored and changes no output.
- R6: When load_en is 0, changes on the bus do not change opcode, operand or op_valid.
- R7: latch_clr drops op_valid at the next rising edge, after which the opcode output reads 0. It also points the next load at the opcode register. A full two-load fetch then brings op_valid back with the new opcode.
- R8: Step zero does not clear the hold latch. After a step-zero cycle while op_valid is 1, the next load still goes to the operand register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 8 | Byte from the shared bus |
| load_en | input | 1 | Load strobe, active high |
| step0_n | input | 1 | Micro-step zero indication, active low |
| latch_clr | input | 1 | Synchronous clear of the hold latch and the load target |
| opcode | output | 4 | Held opcode; reads 0 while not valid |
| operand | output | 8 | Operand register contents |
| op_valid | output | 1 | A fetch has finished and the opcode is held |

## Verification
The load-target bit and the hold latch cannot be seen directly. Each one shows up only one load later.

If the target bit is wrong, a byte lands in the wrong register. The operand then fails to change, or the opcode picks up a nibble it should not have, at the next rising edge after that load.

If the hold latch is wrong, op_valid appears one load too early or too late. Or, once op_valid is set, a later load overwrites the opcode. The tests therefore always end with a load and check all three outputs one cycle after it.

// File: rtl/split_ir.sv
module split_ir #(
  parameter int OPC_W = 4,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             load_en,
  input  logic             step0_n,
  input  logic             latch_clr,
  output logic [OPC_W-1:0] opcode,
  output logic [BUS_W-1:0] operand,
  output logic             op_valid
);
  localparam int OPC_TOP = BUS_W - 1;

  logic [OPC_W-1:0] opc_q;
  logic [BUS_W-1:0] opr_q;
  logic             tgt_opr;
  logic             held;
  logic             ld_ok;
  logic             opc_we;
  logic             opr_we;

  assign ld_ok  = load_en & step0_n;
  assign opc_we = ld_ok & ~tgt_opr & ~held;
  assign opr_we = ld_ok & (tgt_opr | held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q   <= '0;
      opr_q   <= '0;
      tgt_opr <= 1'b0;
      held    <= 1'b0;
    end else begin
      if (opc_we) opc_q <= bus_in[OPC_TOP -: OPC_W];
      if (opr_we) opr_q <= bus_in;
      if (!step0_n || latch_clr) tgt_opr <= 1'b0;
      else if (ld_ok)            tgt_opr <= ~tgt_opr;
      if (latch_clr)             held <= 1'b0;
      else if (opr_we && !held)  held <= 1'b1;
    end
  end

  assign opcode   = held ? opc_q : '0;
  assign operand  = opr_q;
  assign op_valid = held;
endmodule

// File: rtl/split_ir_checker.sv
module split_ir_checker #(
  parameter int OPC_W = 4,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic             step0_n,
  input logic             latch_clr,
  input logic [OPC_W-1:0] opcode,
  input logic [BUS_W-1:0] operand,
  input logic             op_valid
);
  a_r3_hidden_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (opcode == '0));

  a_r3_valid_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> $past(load_en && step0_n));

  a_r4_opcode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !latch_clr) |=> (op_valid && $stable(opcode)));

  a_r5_step0_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !step0_n |=> $stable(operand));

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(operand));

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |=> !op_valid);
endmodule

bind split_ir split_ir_checker #(.OPC_W(OPC_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .step0_n(step0_n),
  .latch_clr(latch_clr), .opcode(opcode), .operand(operand), .op_valid(op_valid)
);

// File: tb/split_ir_tb.sv
module split_ir_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic       load_en = 1'b0;
  logic       step0_n = 1'b1;
  logic       latch_clr = 1'b0;
  logic [3:0] opcode;
  logic [7:0] operand;
  logic       op_valid;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  split_ir u_dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_en(load_en),
    .step0_n(step0_n), .latch_clr(latch_clr),
    .opcode(opcode), .operand(operand), .op_valid(op_valid)
  );

  task automatic chk(input string req, input logic [3:0] e_opc,
                     input logic [7:0] e_opr, input logic e_v);
    n_run++;
    if (opcode !== e_opc || operand !== e_opr || op_valid !== e_v) begin
      n_fail++;
      $display("FAIL %s: opc=%h opr=%h v=%b expected opc=%h opr=%h v=%b",
               req, opcode, operand, op_valid, e_opc, e_opr, e_v);
    end
  endtask

  task automatic cyc(input logic ld, input logic [7:0] b,
                     input logic s0n, input logic clr);
    @(negedge clk);
    load_en = ld; bus_in = b; step0_n = s0n; latch_clr = clr;
    @(negedge clk);
    load_en = 1'b0; step0_n = 1'b1; latch_clr = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 reset values", 4'h0, 8'h00, 1'b0);
  endtask

  task automatic t_fetch;
    do_reset();
    cyc(1'b1, 8'hA7, 1'b1, 1'b0);
    chk("R3 hidden after opcode load", 4'h0, 8'h00, 1'b0);
    cyc(1'b1, 8'h3C, 1'b1, 1'b0);
    chk("R2 fetch opcode and operand", 4'hA, 8'h3C, 1'b1);
  endtask

  task automatic t_held;
    cyc(1'b1, 8'h55, 1'b1, 1'b0);
    chk("R4 held load writes operand only", 4'hA, 8'h55, 1'b1);
    cyc(1'b1, 8'hE9, 1'b1, 1'b0);
    chk("R4 second held load", 4'hA, 8'hE9, 1'b1);
  endtask

  task automatic t_idle_bus;
    cyc(1'b0, 8'hFF, 1'b1, 1'b0);
    chk("R6 bus change without load", 4'hA, 8'hE9, 1'b1);
    cyc(1'b0, 8'h12, 1'b1, 1'b0);
    chk("R6 bus change again", 4'hA, 8'hE9, 1'b1);
  endtask

  task automatic t_step0_held;
    cyc(1'b1, 8'h77, 1'b0, 1'b0);
    chk("R5 load during step zero ignored", 4'hA, 8'hE9, 1'b1);
    cyc(1'b1, 8'hF0, 1'b1, 1'b0);
    chk("R8 step zero keeps hold", 4'hA, 8'hF0, 1'b1);
  endtask

  task automatic t_clear;
    cyc(1'b0, 8'h00, 1'b1, 1'b1);
    chk("R7 clear drops valid", 4'h0, 8'hF0, 1'b0);
    cyc(1'b1, 8'h81, 1'b1, 1'b0);
    chk("R7 opcode load after clear", 4'h0, 8'hF0, 1'b0);
    cyc(1'b1, 8'h22, 1'b1, 1'b0);
    chk("R7 refetch after clear", 4'h8, 8'h22, 1'b1);
  endtask

  task automatic t_step0_unheld;
    do_reset();
    cyc(1'b1, 8'h61, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R5 step zero no output change", 4'h0, 8'h00, 1'b0);
    cyc(1'b1, 8'h92, 1'b1, 1'b0);
    chk("R5 reload targets opcode", 4'h0, 8'h00, 1'b0);
    cyc(1'b1, 8'h44, 1'b1, 1'b0);
    chk("R5 opcode overwritten before fetch end", 4'h9, 8'h44, 1'b1);
  endtask

  task automatic t_async_reset;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async reset without edge", 4'h0, 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_fetch();
    t_held();
    t_idle_bus();
    t_step0_held();
    t_clear();
    t_step0_unheld();
    t_async_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule